// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block supplies the word address for a synchronous burst memory. A burst begins when one of two active-low address strobes captures a base address. One strobe comes from the processor side and one from the controller side. The block then steps through four words of the aligned block that holds that base. It moves one beat forward on each clock edge at which the active-low advance input is low. The upper address bits come straight from the captured base. The two low bits come from a 2-bit beat counter, which is combined with the captured start offset in one of two orders.

A static order-select input picks the order. When it is high, the low bits are the start offset XOR the beat count. When it is low, the low bits are the start offset plus the beat count, modulo four. The processor strobe is accepted only while the active-low chip enable is low in the same cycle. The controller strobe is always accepted. A strobe that is accepted always wins over advance.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and at the first clock after it, `addr_out` is all zeros.
- R2: When `ctrl_strobe_n` is low at a clock edge, `addr_out` equals the `base_addr` sampled at that edge from that edge on.
- R3: When `proc_strobe_n` and `chip_en_n` are both low at a clock edge, `addr_out` equals the sampled `base_addr` from that edge on.
- R4: A low `proc_strobe_n` with `chip_en_n` high (and `ctrl_strobe_n` high) loads nothing: the address is unchanged after that edge.
- R5: At an edge with no accepted strobe and `advance_n` low, the beat count moves forward by one, modulo 4.
- R6: At an edge with no accepted strobe and `advance_n` high, `addr_out` holds its value.
- R7: With `order_sel` low (linear), the low two bits of `addr_out` at beat k are (start + k) mod 4.
- R8: With `order_sel` high (interleaved), the low two bits of `addr_out` at beat k are start XOR k.
- R9: The bits of `addr_out` above the low two change only at an edge where a strobe is accepted.
- R10: A strobe that is accepted together with a low `advance_n` loads the new base and restarts at beat 0. The advance is not applied.
- R11: After the fourth advance of a burst, `addr_out` is back at the start address, and further advances repeat the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | ADDR_W | Word address captured by an accepted strobe |
| chip_en_n | input | 1 | Active-low enable that qualifies the processor strobe |
| proc_strobe_n | input | 1 | Active-low processor-side address strobe |
| ctrl_strobe_n | input | 1 | Active-low controller-side address strobe |
| advance_n | input | 1 | Active-low burst advance |
| order_sel | input | 1 | 1 = interleaved (XOR) order, 0 = linear order |
| addr_out | output | ADDR_W | Current word address |

## Verification
The bench runs full bursts from every start offset in both orders and checks that the sequence wraps back to the start on the fifth beat. A design that carried the count into the upper bits, or that mixed the two orders up, would show a wrong address within one burst. The bench sends a processor strobe while the chip enable is high. A design that ignores the enable would jump to the new base. Strobes that arrive together with advance, in the middle of a burst, catch a design that steps the old burst instead of restarting. Idle cycles catch a counter that drifts while `advance_n` is high.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Encoding of the order-select input.
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    // Kind of update applied at the next clock edge.
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_STEP = 2'd2
    } burst_update_e;

endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
    import burst_pkg::*;
(
    input  logic          chip_en_n,
    input  logic          proc_strobe_n,
    input  logic          ctrl_strobe_n,
    input  logic          advance_n,
    output burst_update_e update
);

    logic proc_take;
    logic ctrl_take;

    always_comb begin
        proc_take = !proc_strobe_n && !chip_en_n;
        ctrl_take = !ctrl_strobe_n;
        if (proc_take || ctrl_take) begin
            update = UPD_LOAD;
        end else if (!advance_n) begin
            update = UPD_STEP;
        end else begin
            update = UPD_HOLD;
        end
    end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  burst_update_e      update,
    output logic [BURST_W-1:0] beat
);

    localparam logic [BURST_W-1:0] BEAT_ONE  = BURST_W'(1);
    localparam logic [BURST_W-1:0] BEAT_ZERO = '0;

    typedef struct packed {
        logic [BURST_W-1:0] beat;
    } cnt_state_t;

    cnt_state_t cnt_d;
    cnt_state_t cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        case (update)
            UPD_LOAD: cnt_d.beat = BEAT_ZERO;
            UPD_STEP: cnt_d.beat = cnt_q.beat + BEAT_ONE;
            default:  cnt_d.beat = cnt_q.beat;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign beat = cnt_q.beat;

    // R5: a step moves the beat forward by one, wrapping
    a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (update == UPD_STEP) |=> (beat == $past(beat) + BEAT_ONE));

    // R10: a load restarts the burst at beat zero whatever advance did
    a_r10_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (update == UPD_LOAD) |=> (beat == BEAT_ZERO));

    // R6: no strobe and no advance leaves the beat alone
    a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (update == UPD_HOLD) |=> $stable(beat));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] start,
    input  logic [BURST_W-1:0] beat,
    input  burst_order_e       order,
    output logic [BURST_W-1:0] offset
);

    logic [BURST_W-1:0] lin_off;
    logic [BURST_W-1:0] xor_off;

    // Interleaved order, one XOR per bit.
    for (genvar b = 0; b < BURST_W; b++) begin : g_xor_bit
        assign xor_off[b] = start[b] ^ beat[b];
    end

    // Linear order: the sum wraps inside the aligned block.
    assign lin_off = start + beat;

    always_comb begin
        if (order == ORDER_INTERLEAVED) begin
            offset = xor_off;
        end else begin
            offset = lin_off;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              chip_en_n,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int UPPER_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BURST_W-1:0] start;
    } base_state_t;

    base_state_t    base_d;
    base_state_t    base_q;
    burst_update_e  update;
    logic [BURST_W-1:0] beat;
    logic [BURST_W-1:0] offset;
    burst_order_e   order;

    assign order = burst_order_e'(order_sel);

    burst_strobe_decode u_decode (
        .chip_en_n     (chip_en_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .update        (update)
    );

    burst_beat_counter #(
        .BURST_W (BURST_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .update (update),
        .beat   (beat)
    );

    always_comb begin
        base_d = base_q;
        if (update == UPD_LOAD) begin
            base_d.upper = base_addr[ADDR_W-1:BURST_W];
            base_d.start = base_addr[BURST_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    burst_order_map #(
        .BURST_W (BURST_W)
    ) u_map (
        .start  (base_q.start),
        .beat   (beat),
        .order  (order),
        .offset (offset)
    );

    assign addr_out = {base_q.upper, offset};

    // R2: controller strobe captures the base address
    a_r2_ctrl_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_strobe_n |=> (addr_out == $past(base_addr)));

    // R3: processor strobe with chip enable captures the base address
    a_r3_proc_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !chip_en_n) |=> (addr_out == $past(base_addr)));

    // R4: processor strobe without chip enable changes nothing
    a_r4_proc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_strobe_n && !proc_strobe_n && chip_en_n && advance_n)
        |=> ($stable(base_q) && $stable(beat)));

    // R9: upper bits move only on an accepted strobe
    a_r9_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_strobe_n && (proc_strobe_n || chip_en_n))
        |=> $stable(addr_out[ADDR_W-1:BURST_W]));

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 15;
    localparam int WATCHDOG   = 200000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] base_addr;
    logic              chip_en_n;
    logic              proc_strobe_n;
    logic              ctrl_strobe_n;
    logic              advance_n;
    logic              order_sel;
    logic [ADDR_W-1:0] addr_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(2)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .base_addr     (base_addr),
        .chip_en_n     (chip_en_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .order_sel     (order_sel),
        .addr_out      (addr_out)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            fails++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // One clock edge, then settle away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        chip_en_n     = 1'b1;
        proc_strobe_n = 1'b1;
        ctrl_strobe_n = 1'b1;
        advance_n     = 1'b1;
    endtask

    function automatic logic [ADDR_W-1:0] expect_beat(
        input logic [ADDR_W-1:0] base, input int k, input logic inter);
        logic [1:0] s;
        logic [1:0] kk;
        s  = base[1:0];
        kk = 2'(k);
        return {base[ADDR_W-1:2], inter ? (s ^ kk) : 2'(s + kk)};
    endfunction

    task automatic load_ctrl(input logic [ADDR_W-1:0] a);
        idle_inputs();
        base_addr     = a;
        ctrl_strobe_n = 1'b0;
        tick();
        idle_inputs();
    endtask

    task automatic t_reset();
        idle_inputs();
        base_addr = 15'h5A5A;
        order_sel = 1'b0;
        rst_n     = 1'b0;
        tick();
        tick();
        check("R1 reset", '0);
        rst_n = 1'b1;
        tick();
        check("R1 first clock after reset", '0);
    endtask

    task automatic t_burst(input logic [ADDR_W-1:0] a, input logic inter,
                           input logic via_proc);
        idle_inputs();
        order_sel = inter;
        base_addr = a;
        if (via_proc) begin
            proc_strobe_n = 1'b0;
            chip_en_n     = 1'b0;
        end else begin
            ctrl_strobe_n = 1'b0;
        end
        tick();
        idle_inputs();
        base_addr = ~a;
        check(via_proc ? "R3 proc load" : "R2 ctrl load", a);
        for (int k = 1; k <= 8; k++) begin
            advance_n = 1'b0;
            tick();
            if (k % 4 == 0)
                check("R11 wrap to start", a);
            else if (inter)
                check("R8 interleaved beat / R9 upper", expect_beat(a, k, 1'b1));
            else
                check("R7 linear beat / R5 / R9 upper", expect_beat(a, k, 1'b0));
        end
        idle_inputs();
    endtask

    task automatic t_proc_gated();
        order_sel = 1'b0;
        load_ctrl(15'h0124);
        advance_n = 1'b0;
        tick();
        idle_inputs();
        base_addr     = 15'h7FFF;
        proc_strobe_n = 1'b0;
        chip_en_n     = 1'b1;
        tick();
        idle_inputs();
        check("R4 proc strobe ignored without chip enable", 15'h0125);
        advance_n = 1'b0;
        tick();
        idle_inputs();
        check("R4 burst continues after ignored strobe", 15'h0126);
    endtask

    task automatic t_hold();
        order_sel = 1'b1;
        load_ctrl(15'h3333);
        advance_n = 1'b0;
        tick();
        idle_inputs();
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 hold without advance", 15'h3332);
        end
        advance_n = 1'b0;
        tick();
        idle_inputs();
        check("R6 resumes after hold", 15'h3331);
    endtask

    task automatic t_priority();
        order_sel = 1'b0;
        load_ctrl(15'h1001);
        advance_n = 1'b0;
        tick();
        tick();
        base_addr     = 15'h2222;
        ctrl_strobe_n = 1'b0;
        tick();
        ctrl_strobe_n = 1'b1;
        check("R10 ctrl strobe beats advance", 15'h2222);
        base_addr     = 15'h4447;
        proc_strobe_n = 1'b0;
        chip_en_n     = 1'b0;
        tick();
        idle_inputs();
        check("R10 proc strobe beats advance", 15'h4447);
        advance_n = 1'b0;
        tick();
        idle_inputs();
        check("R10 restart at beat 0 then R7 step", 15'h4444);
    endtask

    initial begin
        t_reset();
        for (int s = 0; s < 4; s++) begin
            t_burst(15'h1230 | 15'(s), 1'b0, 1'b0);
            t_burst(15'h6A5C | 15'(s), 1'b1, 1'b1);
        end
        t_burst(15'h7FFD, 1'b0, 1'b1);
        t_burst(15'h0002, 1'b1, 1'b0);
        t_proc_gated();
        t_hold();
        t_priority();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule